// File: doc/BRIEF.md
# MDIO Management Master with Child-Bus Selector

This block is a station-management master for Ethernet PHYs, run by software through a small word-addressed register file. Software picks a child bus, a PHY address and a register number, then writes a command word. The block then sends a complete management frame on MDC/MDIO. It supports the short-address frame format (Clause 22) and the extended format (Clause 45). An extended access is sent as an address frame followed by a data frame. Software polls a done flag, collects any read data, and clears the flag by writing zero to the command register.

The child buses are split into an internal group and an external group. A group-select bit and a bus-number field in the parameter register pick one bus from those groups. Only that bus sees MDC toggle, and only its MDIO input is listened to. An accumulator turns the core clock into MDC half-period ticks at a programmable rate. A separate control bit exports a signal that locks any other management master off the buses.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset, STATUS (word 1) and RDATA (word 4) read 0, RATE (word 5) reads 0x0001_0002, every `mdc_o` and `mdio_oe` bit is 0, and `ext_mgmt_block` is 0.
- R2: Writing 1 to CTRL (word 0) while idle starts a Clause 22 write frame when PARAM (word 2) bit 21 is 0. The frame is 32 ones, start 01, opcode 01, the PHY address (PARAM[20:16]), the register number (ADDR[4:0], word 3), turnaround 10, and PARAM[15:0]. All bits are sent MSB first, one bit per MDC period, changed after a falling MDC edge and driven throughout.
- R3: Writing 2 to CTRL starts a read frame with opcode 10. The master releases MDIO (`mdio_oe`=0) for frame bits 46 to 63, which are the turnaround and data bits. It samples the 16 data bits on rising MDC edges. On completion it places them in RDATA[15:0], and RDATA[31:16] reads 0.
- R4: With PARAM bit 21 set, the block sends two frames back to back. The first is an address frame (start 00, opcode 00, PHY address, device address ADDR[20:16], turnaround 10, ADDR[15:0]). The second uses opcode 01 for a write or 11 for a read, with the same two 5-bit fields and the write data or a released read field.
- R5: STATUS bit 0 is 0 while a transaction runs and 1 once its last frame ends. Writing 0 to CTRL returns it to 0.
- R6: Writing 0 to CTRL during a transaction abandons it at once. MDC stops low, MDIO is released, no more frame edges appear, and the next command runs normally.
- R7: A CTRL write of 1 or 2 is ignored unless the engine is idle. This holds both while a transaction runs and while done is still set.
- R8: PARAM bit 25 set with bus number PARAM[24:22]=k selects internal bus k (port index k). Bit 25 clear selects external bus k (port index INT_BUSES+k). Every other bus keeps MDC low and MDIO released, and only the selected bus's `mdio_in` is sampled.
- R9: A bus number beyond the selected group's size leaves every bus quiet. The transaction still completes and sets done.
- R10: RATE holds a divisor in bits [7:0] and a dividend in bits [23:16]. Each core cycle the accumulator adds the dividend and, on reaching the divisor, emits one MDC half-period tick. The MDC period is therefore 2*divisor/dividend core cycles. A divisor of 0 acts as 1.
- R11: Writes to PARAM, ADDR and RATE are ignored while a transaction runs. The frame in flight keeps the values latched at start.
- R12: SCAN (word 6) bit 28 drives `ext_mgmt_block` from the cycle after the write and reads back in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc_o | output | INT_BUSES+EXT_BUSES | MDC per child bus |
| mdio_out | output | INT_BUSES+EXT_BUSES | MDIO output value per child bus |
| mdio_oe | output | INT_BUSES+EXT_BUSES | MDIO output enable per child bus |
| mdio_in | input | INT_BUSES+EXT_BUSES | MDIO input per child bus |
| ext_mgmt_block | output | 1 | Locks other management masters off the buses |

## Verification
Configuration writes and command writes can arrive in the same window as a running frame. The bench provokes this by rewriting PARAM, RATE and CTRL in the middle of a transfer. It then judges the captured bit stream against a frame built from the values set before the start, and reads the registers back to confirm that the writes were dropped. A clear that lands while MDC is mid-frame is judged by counting MDC edges on all buses afterwards and by checking that the next transaction's frames are exact.

// File: rtl/mdio_mux_pkg.sv
// Package: shared register word addresses, field positions, command codes,
// engine state type and the latched transaction descriptor.
package mdio_mux_pkg;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_STAT  = 3'd1;
    localparam logic [2:0] REG_PARAM = 3'd2;
    localparam logic [2:0] REG_ADDR  = 3'd3;
    localparam logic [2:0] REG_RDATA = 3'd4;
    localparam logic [2:0] REG_RATE  = 3'd5;
    localparam logic [2:0] REG_SCAN  = 3'd6;

    localparam int PRM_PA_LSB  = 16;
    localparam int PRM_C45_BIT = 21;
    localparam int PRM_BUS_LSB = 22;
    localparam int PRM_INT_BIT = 25;
    localparam int ADR_DEV_LSB = 16;
    localparam int RATE_DVD_LSB = 16;
    localparam int SCAN_BLK_BIT = 28;

    localparam logic [31:0] CMD_WRITE = 32'd1;
    localparam logic [31:0] CMD_READ  = 32'd2;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_DONE = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic        c45;
        logic        rd;
        logic [4:0]  pa;
        logic [4:0]  dev;
        logic [15:0] regn;
        logic [15:0] wdata;
    } xfer_t;

endpackage

// File: rtl/mdio_cfg_regs.sv
// Register file: holds parameter, address, rate and scan-control words,
// decodes command writes into start/clear pulses and forms read data.
// Assumes DIV_W <= 16. PARAM, ADDR and RATE are frozen while busy is high.
module mdio_cfg_regs
    import mdio_mux_pkg::*;
#(
    parameter int DIV_W        = 8,
    parameter int RST_DIVISOR  = 2,
    parameter int RST_DIVIDEND = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             busy,
    input  logic             done,
    input  logic [15:0]      rd16,
    output logic [31:0]      rdata,
    output logic             start_req,
    output logic             clear_req,
    output xfer_t            xfer,
    output logic             bus_int,
    output logic [2:0]       bus_id,
    output logic [DIV_W-1:0] divisor,
    output logic [DIV_W-1:0] dividend,
    output logic             ext_block,
    output logic [31:0]      param_word
);
    localparam int PRM_W = PRM_INT_BIT + 1;
    localparam int ADR_W = ADR_DEV_LSB + 5;

    logic [PRM_W-1:0] prm_q;
    logic [ADR_W-1:0] adr_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] dvd_q;
    logic             scan_q;
    logic             ctrl_wr;

    assign ctrl_wr   = wr && (addr == REG_CTRL);
    assign start_req = ctrl_wr && ((wdata == CMD_WRITE) || (wdata == CMD_READ));
    assign clear_req = ctrl_wr && (wdata == 32'd0);

    // Register storage; configuration words locked while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prm_q  <= '0;
            adr_q  <= '0;
            div_q  <= DIV_W'(RST_DIVISOR);
            dvd_q  <= DIV_W'(RST_DIVIDEND);
            scan_q <= 1'b0;
        end else if (wr) begin
            case (addr)
                REG_PARAM: if (!busy) prm_q <= wdata[PRM_W-1:0];
                REG_ADDR:  if (!busy) adr_q <= wdata[ADR_W-1:0];
                REG_RATE:  if (!busy) begin
                    div_q <= wdata[DIV_W-1:0];
                    dvd_q <= wdata[RATE_DVD_LSB +: DIV_W];
                end
                REG_SCAN:  scan_q <= wdata[SCAN_BLK_BIT];
                default: ;
            endcase
        end
    end

    // Transaction descriptor handed to the engine at start.
    always_comb begin
        xfer.c45   = prm_q[PRM_C45_BIT];
        xfer.rd    = (wdata == CMD_READ);
        xfer.pa    = prm_q[PRM_PA_LSB +: 5];
        xfer.wdata = prm_q[15:0];
        xfer.dev   = adr_q[ADR_DEV_LSB +: 5];
        xfer.regn  = adr_q[15:0];
    end

    assign bus_int    = prm_q[PRM_INT_BIT];
    assign bus_id     = prm_q[PRM_BUS_LSB +: 3];
    assign divisor    = div_q;
    assign dividend   = dvd_q;
    assign ext_block  = scan_q;
    assign param_word = {{(32-PRM_W){1'b0}}, prm_q};

    // Read-data multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_STAT:  rdata[0] = done;
            REG_PARAM: rdata = param_word;
            REG_ADDR:  rdata[ADR_W-1:0] = adr_q;
            REG_RDATA: rdata[15:0] = rd16;
            REG_RATE: begin
                rdata[DIV_W-1:0] = div_q;
                rdata[RATE_DVD_LSB +: DIV_W] = dvd_q;
            end
            REG_SCAN:  rdata[SCAN_BLK_BIT] = scan_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/mdio_rate_gen.sv
// Rate accumulator: adds the dividend each core cycle and emits a tick when
// the sum reaches the divisor (divisor 0 acts as 1). Cleared while not run.
module mdio_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    input  logic [DIV_W-1:0] dividend,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] div_eff;
    logic [ACC_W-1:0] sum;
    logic             fast;

    assign div_eff = (divisor == '0) ? ACC_W'(1) : {1'b0, divisor};
    assign sum     = acc_q + {1'b0, dividend};
    assign fast    = ({1'b0, dividend} >= div_eff);
    assign tick    = run && (sum >= div_eff);

    // Accumulator step, wrap on tick, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  acc_q <= '0;
        else if (tick)       acc_q <= fast ? '0 : (sum - div_eff);
        else                 acc_q <= sum;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: serialises one (short format) or two (extended format)
// 64-bit management frames. MDC rises and falls on rate ticks; data changes
// after a falling edge and input is sampled on a rising edge. A clear
// request aborts a run or leaves the done state.
module mdio_frame_engine
    import mdio_mux_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start,
    input  logic        clear,
    input  xfer_t       xfer,
    input  logic        mdi,
    output logic        mdc,
    output logic        mdo,
    output logic        mdoe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam logic [5:0] LAST_BIT   = 6'd63;
    localparam logic [5:0] TA_BIT     = 6'd46;
    localparam logic [5:0] DATA_BIT   = 6'd48;
    localparam logic [5:0] PREAMBLE_N = 6'd32;

    eng_state_t  st_q;
    xfer_t       x_q;
    logic [5:0]  cnt_q;
    logic        sec_q;
    logic        mdc_q;
    logic [15:0] sh_q;
    logic [15:0] rd_q;
    logic        rd_frame;
    logic [31:0] word;
    logic        bit_val;

    assign rd_frame = x_q.rd && (!x_q.c45 || sec_q);

    // Build the post-preamble 32-bit frame word for the current frame.
    always_comb begin
        if (!x_q.c45)
            word = {2'b01, (x_q.rd ? 2'b10 : 2'b01), x_q.pa, x_q.regn[4:0],
                    2'b10, x_q.wdata};
        else if (!sec_q)
            word = {4'b0000, x_q.pa, x_q.dev, 2'b10, x_q.regn};
        else
            word = {2'b00, (x_q.rd ? 2'b11 : 2'b01), x_q.pa, x_q.dev,
                    2'b10, x_q.wdata};
    end

    assign bit_val = (cnt_q < PREAMBLE_N) ? 1'b1 : word[~cnt_q[4:0]];
    assign mdo     = (st_q == ENG_RUN) && bit_val;
    assign mdoe    = (st_q == ENG_RUN) && !(rd_frame && (cnt_q >= TA_BIT));
    assign mdc     = mdc_q;
    assign busy    = (st_q == ENG_RUN);
    assign done    = (st_q == ENG_DONE);
    assign rd_data = rd_q;

    // Sequencer: start, MDC phases, bit counting, frame chaining, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ENG_IDLE;
            x_q   <= '0;
            cnt_q <= '0;
            sec_q <= 1'b0;
            mdc_q <= 1'b0;
            sh_q  <= '0;
            rd_q  <= '0;
        end else begin
            case (st_q)
                ENG_IDLE: if (start) begin
                    st_q  <= ENG_RUN;
                    x_q   <= xfer;
                    cnt_q <= '0;
                    sec_q <= 1'b0;
                    mdc_q <= 1'b0;
                    sh_q  <= '0;
                end
                ENG_RUN: begin
                    if (clear) begin
                        st_q  <= ENG_IDLE;
                        mdc_q <= 1'b0;
                    end else if (tick) begin
                        if (!mdc_q) begin
                            mdc_q <= 1'b1;
                            if (rd_frame && (cnt_q >= DATA_BIT))
                                sh_q <= {sh_q[14:0], mdi};
                        end else begin
                            mdc_q <= 1'b0;
                            if (cnt_q == LAST_BIT) begin
                                cnt_q <= '0;
                                if (x_q.c45 && !sec_q) begin
                                    sec_q <= 1'b1;
                                end else begin
                                    st_q <= ENG_DONE;
                                    if (x_q.rd) rd_q <= sh_q;
                                end
                            end else begin
                                cnt_q <= cnt_q + 6'd1;
                            end
                        end
                    end
                end
                ENG_DONE: if (clear) st_q <= ENG_IDLE;
                default: st_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_bus_mux.sv
// Child-bus selector: steers MDC/MDIO to one bus chosen by group bit and bus
// number; all other buses hold MDC low with MDIO released. The returned
// input idles high when no bus matches. Assumes INT_N and EXT_N <= 8.
module mdio_bus_mux #(
    parameter int INT_N = 4,
    parameter int EXT_N = 4,
    localparam int NB   = INT_N + EXT_N
) (
    input  logic          bus_int,
    input  logic [2:0]    bus_id,
    input  logic          mdc,
    input  logic          mdo,
    input  logic          mdoe,
    input  logic [NB-1:0] mdio_in,
    output logic [NB-1:0] mdc_o,
    output logic [NB-1:0] mdio_out,
    output logic [NB-1:0] mdio_oe,
    output logic          mdi
);
    logic [NB-1:0] hit;

    for (genvar b = 0; b < NB; b++) begin : g_bus
        localparam bit IS_INT = (b < INT_N);
        localparam int IDX    = IS_INT ? b : b - INT_N;
        assign hit[b]      = (bus_int == IS_INT) && (bus_id == 3'(IDX));
        assign mdc_o[b]    = hit[b] && mdc;
        assign mdio_out[b] = hit[b] && mdo;
        assign mdio_oe[b]  = hit[b] && mdoe;
    end

    // Return path from the selected bus only.
    always_comb begin
        mdi = 1'b1;
        for (int b = 0; b < NB; b++)
            if (hit[b]) mdi = mdio_in[b];
    end
endmodule

// File: rtl/mdio_mux_master.sv
// Top: register-mapped MDIO master with child-bus selection. Connects the
// register file, rate accumulator, frame engine and bus selector.
module mdio_mux_master
    import mdio_mux_pkg::*;
#(
    parameter int INT_BUSES    = 4,
    parameter int EXT_BUSES    = 4,
    parameter int DIV_W        = 8,
    parameter int RST_DIVISOR  = 2,
    parameter int RST_DIVIDEND = 1,
    localparam int NB          = INT_BUSES + EXT_BUSES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [NB-1:0] mdc_o,
    output logic [NB-1:0] mdio_out,
    output logic [NB-1:0] mdio_oe,
    input  logic [NB-1:0] mdio_in,
    output logic          ext_mgmt_block
);
    logic             eng_busy;
    logic             eng_done;
    logic [15:0]      eng_rd;
    logic             start_req;
    logic             clear_req;
    xfer_t            xfer;
    logic             bus_int;
    logic [2:0]       bus_id;
    logic [DIV_W-1:0] divisor;
    logic [DIV_W-1:0] dividend;
    logic [31:0]      param_word;
    logic             tick;
    logic             e_mdc;
    logic             e_mdo;
    logic             e_mdoe;
    logic             e_mdi;

    mdio_cfg_regs #(
        .DIV_W(DIV_W), .RST_DIVISOR(RST_DIVISOR), .RST_DIVIDEND(RST_DIVIDEND)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .busy(eng_busy), .done(eng_done), .rd16(eng_rd),
        .rdata(reg_rdata), .start_req(start_req), .clear_req(clear_req),
        .xfer(xfer), .bus_int(bus_int), .bus_id(bus_id), .divisor(divisor),
        .dividend(dividend), .ext_block(ext_mgmt_block),
        .param_word(param_word)
    );

    mdio_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .divisor(divisor),
        .dividend(dividend), .tick(tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_req),
        .clear(clear_req), .xfer(xfer), .mdi(e_mdi), .mdc(e_mdc),
        .mdo(e_mdo), .mdoe(e_mdoe), .busy(eng_busy), .done(eng_done),
        .rd_data(eng_rd)
    );

    mdio_bus_mux #(.INT_N(INT_BUSES), .EXT_N(EXT_BUSES)) u_mux (
        .bus_int(bus_int), .bus_id(bus_id), .mdc(e_mdc), .mdo(e_mdo),
        .mdoe(e_mdoe), .mdio_in(mdio_in), .mdc_o(mdc_o),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdi(e_mdi)
    );
endmodule

// File: rtl/mdio_mux_master_chk.sv
// Checker: temporal properties on the top module, attached by bind.
module mdio_mux_master_chk
    import mdio_mux_pkg::*;
#(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic [NB-1:0] mdc_o,
    input logic [NB-1:0] mdio_oe,
    input logic          ext_mgmt_block,
    input logic          busy,
    input logic          done,
    input logic [31:0]   param_word
);
    logic clr_wr;
    assign clr_wr = reg_wr && (reg_addr == REG_CTRL) && (reg_wdata == 32'd0);

    p_one_mdc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdc_o));
    p_one_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdio_oe));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mdc_o == '0 && mdio_oe == '0));
    p_clear_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !done);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr_wr) |=> done);
    p_cfg_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == REG_PARAM) |=> $stable(param_word));
    p_rdata_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_RDATA) |-> (reg_rdata[31:16] == 16'd0));
    p_scan_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_SCAN) |=> (ext_mgmt_block == $past(reg_wdata[SCAN_BLK_BIT])));
endmodule

bind mdio_mux_master mdio_mux_master_chk #(.NB(NB)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
    .mdio_oe(mdio_oe), .ext_mgmt_block(ext_mgmt_block), .busy(eng_busy),
    .done(eng_done), .param_word(param_word)
);

// File: tb/test_mdio_mux_master.sv
module test_mdio_mux_master;
    localparam int INT_N = 4;
    localparam int EXT_N = 4;
    localparam int NB    = INT_N + EXT_N;
    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_PARAM = 3'd2,
        A_ADDR = 3'd3, A_RDATA = 3'd4, A_RATE = 3'd5, A_SCAN = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NB-1:0] mdc_o, mdio_out, mdio_oe;
    logic [NB-1:0] mdio_in = '1;
    logic ext_mgmt_block;

    int errs = 0, checks = 0;
    int tb_sel = -1, n_rise = 0, stray = 0, any_rise = 0;
    longint cyc = 0;
    longint rise_t [3];
    logic [127:0] cap_bit, cap_oe;
    logic [15:0] rsp = '0;
    logic [NB-1:0] prev_mdc = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_mux_master #(.INT_BUSES(INT_N), .EXT_BUSES(EXT_N)) i_mdio_mux_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
        .ext_mgmt_block(ext_mgmt_block)
    );

    function automatic logic resp_bit(input int n, input logic [15:0] d);
        int k = n % 64;
        if (k >= 48) return d[63-k];
        return (k == 47) ? 1'b0 : 1'b1;
    endfunction

    // PHY responder and bus monitor, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        for (int b = 0; b < NB; b++) begin
            if (mdc_o[b] && !prev_mdc[b]) begin
                any_rise++;
                if (b == tb_sel) begin
                    if (n_rise < 128) begin
                        cap_bit[n_rise] = mdio_out[b];
                        cap_oe[n_rise]  = mdio_oe[b];
                    end
                    if (n_rise < 3) rise_t[n_rise] = cyc;
                    n_rise++;
                end
            end
            if (b != tb_sel && (mdc_o[b] || mdio_oe[b])) stray++;
        end
        prev_mdc = mdc_o;
        for (int b = 0; b < NB; b++)
            mdio_in[b] = (b == tb_sel) ? resp_bit(n_rise, rsp) : 1'b0;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input string rq);
        logic [31:0] v = '0;
        for (int i = 0; i < 40000 && !v[0]; i++) rdreg(A_STAT, v);
        chk(v[0], rq, "done reached", v, 1);
    endtask

    function automatic logic [63:0] frm(input bit c45, input bit rd, input bit sec,
        input logic [4:0] pa, input logic [4:0] f2, input logic [15:0] regn,
        input logic [15:0] wd);
        logic [1:0] s, op;
        logic [15:0] dat;
        if (!c45) begin s = 2'b01; op = rd ? 2'b10 : 2'b01; dat = wd; end
        else if (!sec) begin s = 2'b00; op = 2'b00; dat = regn; end
        else begin s = 2'b00; op = rd ? 2'b11 : 2'b01; dat = wd; end
        return {32'hFFFF_FFFF, s, op, pa, f2, 2'b10, dat};
    endfunction

    task automatic launch(input bit ints, input int id, input bit c45, input bit rd,
        input logic [4:0] pa, input logic [4:0] dev, input logic [15:0] regn,
        input logic [15:0] wd, input logic [15:0] r, input int sel);
        wr(A_CTRL, 0);
        wr(A_PARAM, (32'(ints) << 25) | (32'(id) << 22) | (32'(c45) << 21) |
                    (32'(pa) << 16) | 32'(wd));
        wr(A_ADDR, (32'(dev) << 16) | 32'(regn));
        rsp = r; n_rise = 0; stray = 0; tb_sel = sel;
        wr(A_CTRL, rd ? 2 : 1);
    endtask

    task automatic verify(input string rq, input bit c45, input bit rd,
        input logic [4:0] pa, input logic [4:0] dev, input logic [15:0] regn,
        input logic [15:0] wd, input logic [15:0] r);
        int nf = c45 ? 2 : 1;
        logic [31:0] v;
        chk(n_rise == nf*64, rq, "MDC rising edges", n_rise, nf*64);
        chk(stray == 0, "R8", "activity on unselected buses", stray, 0);
        for (int f = 0; f < nf; f++) begin
            logic [63:0] w = frm(c45, rd, f == 1, pa, c45 ? dev : regn[4:0], regn, wd);
            logic [63:0] m = (rd && (!c45 || f == 1)) ? ~64'h3FFFF : '1;
            logic [63:0] aw, ao;
            for (int i = 0; i < 64; i++) begin
                aw[63-i] = cap_bit[f*64+i];
                ao[63-i] = cap_oe[f*64+i];
            end
            chk(ao == m && (aw & m) == (w & m), rq, $sformatf("frame %0d bits", f), aw, w);
        end
        if (rd) begin
            rdreg(A_RDATA, v);
            chk(v == {16'h0, r}, rq, "read data", v, {16'h0, r});
        end
    endtask

    task automatic full(input string rq, input bit ints, input int id, input bit c45,
        input bit rd, input logic [4:0] pa, input logic [4:0] dev,
        input logic [15:0] regn, input logic [15:0] wd, input logic [15:0] r);
        int sel = ints ? id : INT_N + id;
        launch(ints, id, c45, rd, pa, dev, regn, wd, r, sel);
        wait_done(rq);
        verify(rq, c45, rd, pa, dev, regn, wd, r);
    endtask

    task automatic period(input string rq, input int d, input int n, input longint exp);
        wr(A_RATE, (32'(n) << 16) | 32'(d));
        full(rq, 1, 0, 0, 0, 5'd3, 5'd0, 16'd2, 16'h1234, 16'h0);
        chk(rise_t[2] - rise_t[1] == exp, rq, "MDC period", rise_t[2] - rise_t[1], exp);
    endtask

    initial begin
        logic [31:0] v;
        int snap;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rdreg(A_STAT, v);  chk(v == 0, "R1", "status", v, 0);
        rdreg(A_RDATA, v); chk(v == 0, "R1", "rdata", v, 0);
        rdreg(A_RATE, v);  chk(v == 32'h0001_0002, "R1", "rate", v, 32'h0001_0002);
        chk(mdc_o == 0 && mdio_oe == 0 && !ext_mgmt_block, "R1", "outputs",
            {mdc_o, mdio_oe, 7'b0, ext_mgmt_block}, 0);
        // R12: scan block bit
        wr(A_SCAN, 32'h1000_0000);
        chk(ext_mgmt_block, "R12", "block set", ext_mgmt_block, 1);
        rdreg(A_SCAN, v); chk(v == 32'h1000_0000, "R12", "readback", v, 32'h1000_0000);
        wr(A_SCAN, 0);
        chk(!ext_mgmt_block, "R12", "block clear", ext_mgmt_block, 0);
        // R10: rate generator
        full("R10", 1, 0, 0, 0, 5'd3, 5'd0, 16'd2, 16'h1234, 16'h0);
        chk(rise_t[2] - rise_t[1] == 4, "R10", "reset period", rise_t[2] - rise_t[1], 4);
        period("R10", 3, 1, 6);
        period("R10", 5, 2, 5);
        period("R10", 0, 1, 2);
        wr(A_RATE, 32'h0001_0001);
        // R2, R3, R4: frame formats
        full("R2", 1, 1, 0, 0, 5'h15, 5'd0, 16'h0011, 16'hBEEF, 16'h0);
        full("R3", 0, 2, 0, 1, 5'h0A, 5'd0, 16'h001E, 16'h0, 16'hA5C3);
        full("R4", 1, 0, 1, 0, 5'h01, 5'h1F, 16'h8001, 16'h5A5A, 16'h0);
        full("R4", 0, 3, 1, 1, 5'h1E, 5'h07, 16'hC0DE, 16'h0, 16'h7E81);
        // R5: done status
        rdreg(A_STAT, v); chk(v == 1, "R5", "done after finish", v, 1);
        // R7: start ignored while done
        snap = any_rise;
        wr(A_CTRL, 1);
        repeat (30) @(negedge clk);
        chk(any_rise == snap, "R7", "no restart from done", any_rise, snap);
        rdreg(A_STAT, v); chk(v == 1, "R7", "done kept", v, 1);
        wr(A_CTRL, 0);
        rdreg(A_STAT, v); chk(v == 0, "R5", "cleared", v, 0);
        // R11 and R7: writes during a run are dropped
        launch(0, 1, 0, 0, 5'h04, 5'd0, 16'h0009, 16'h0F0F, 16'h0, INT_N + 1);
        repeat (20) @(negedge clk);
        rdreg(A_STAT, v); chk(v == 0, "R5", "busy reads 0", v, 0);
        wr(A_PARAM, 32'h0200_FFFF);
        wr(A_RATE, 32'h0001_0009);
        wr(A_CTRL, 2);
        rdreg(A_PARAM, v);
        chk(v == 32'h0044_0F0F, "R11", "param locked", v, 32'h0044_0F0F);
        rdreg(A_RATE, v); chk(v == 32'h0001_0001, "R11", "rate locked", v, 32'h0001_0001);
        wait_done("R11");
        verify("R11", 0, 0, 5'h04, 5'd0, 16'h0009, 16'h0F0F, 16'h0);
        // R6: abort mid-transaction
        launch(1, 2, 1, 1, 5'h02, 5'h03, 16'h0100, 16'h0, 16'hFFFF, 2);
        repeat (40) @(negedge clk);
        wr(A_CTRL, 0);
        @(negedge clk);
        snap = any_rise;
        repeat (20) @(negedge clk);
        chk(any_rise == snap && mdc_o == 0 && mdio_oe == 0, "R6", "quiet after abort",
            any_rise - snap, 0);
        rdreg(A_STAT, v); chk(v == 0, "R6", "status after abort", v, 0);
        full("R6", 1, 3, 0, 1, 5'h11, 5'd0, 16'h0002, 16'h0, 16'h0123);
        // R9: out-of-range bus number
        launch(1, 6, 0, 0, 5'h01, 5'd0, 16'h0001, 16'h1111, 16'h0, -1);
        wait_done("R9");
        chk(stray == 0, "R9", "no bus active", stray, 0);
        // R8: random transactions over both groups
        for (int t = 0; t < 14; t++) begin
            bit ints = 1'($urandom);
            int id = int'($urandom % 4);
            bit c45 = 1'($urandom);
            bit rd = 1'($urandom);
            full("R8", ints, id, c45, rd, 5'($urandom), 5'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule